// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Engine

This block is the device side of a byte-wide nonvolatile memory. A host drives it through chip-enable, output-enable and write-enable strobes, which the block samples on its own system clock. A host write places a byte into a page buffer that holds 128 bytes. Every byte in one load must share the same page bits of the address. When the host stops sending bytes for longer than a load window, the block starts a programming period. At the end of that period it copies into the storage array only the bytes that were actually loaded.

While programming runs, a read returns status in place of array data. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 changes value on each new read. A separate command detector supplies an `unlock` level, and a new load can begin only while that level is high. The strobe path has no valid/ready handshake and never stalls the host. A strobe the block cannot take is dropped. The host paces itself by watching `busy` or by polling status reads. The storage array is a register array. It implements `2**ARRAY_PAGES_LOG2` pages, and higher page numbers alias onto those pages.

Top module: `pgeep_write_engine`

## Requirements
- R1: After reset, `busy` is 0, `dout_en` is 0 and every array byte reads 8'hFF.
- R2: `dout_en` is 1 exactly when `ce_n` and `oe_n` are both 0. While idle, `dout` then returns the array byte at `addr`. When `dout_en` is 0, `dout` is 0.
- R3: A write strobe is the interval in which `ce_n` and `we_n` are both 0 while `oe_n` is 1. The address is taken when that interval begins, and the data is taken from its last cycle. If `oe_n` drops during the interval, the strobe is cancelled and nothing is loaded.
- R4: A strobe that arrives while idle starts a load only if `unlock` is 1. Otherwise it is dropped and nothing is programmed.
- R5: Once a load has begun, a strobe whose address bits [16:7] differ from those of the first byte is dropped.
- R6: Address bits [6:0] pick the byte in the page, and bytes may arrive in any order. A later strobe to the same byte replaces the earlier one. Bytes of the page that were not loaded keep their previous array value.
- R7: Programming (`busy` = 1) starts between BLC_CYCLES and BLC_CYCLES+3 clock cycles after the clock edge following the end of the last accepted strobe.
- R8: `busy` stays 1 for exactly PROG_CYCLES cycles. No strobe is accepted while it is 1.
- R9: While `busy` is 1, read bit 7 is the complement of bit 7 of the last accepted byte.
- R10: While `busy` is 1, bit 6 is 1 on the first read after programming starts and is inverted on each later read. A read begins when `ce_n` and `oe_n` become both 0.
- R11: After `busy` falls, reads return the stored byte on all bits, and bit 6 no longer alternates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address; bits [16:7] give the page |
| din | input | 8 | Write data |
| unlock | input | 1 | Write permission from the command detector |
| dout | output | 8 | Read data or programming status |
| dout_en | output | 1 | Drive enable for the external data bus |
| busy | output | 1 | High while a programming period is running |

## Verification
The assertions assume that strobe inputs change between clock edges and hold each level for at least one full cycle. They also assume that `din` stays steady while a write strobe is active, so that the sampled interval boundaries are exact. The bench changes every input one time unit after a rising edge and holds each strobe phase for one or two whole cycles. It spaces the page-load writes well inside the load window and never lets `oe_n` bounce within a single read. The bench measures `busy` on falling edges, so the length of the programming period is counted in whole cycles.

// File: rtl/pgeep_pkg.sv
package pgeep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eng_state_t;
endpackage

// File: rtl/pgeep_strobe.sv
// Turns sampled strobe levels into one-cycle write events and read starts.
module pgeep_strobe #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              evt_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [DATA_W-1:0] evt_data_o,
  output logic              rd_act_o,
  output logic              rd_start_o
);
  logic act, act_q, rd_q;

  // Write interval: both enables low, output enable high (R3).
  assign act        = !ce_n && !we_n && oe_n;
  assign rd_act_o   = !ce_n && !oe_n;
  assign rd_start_o = rd_act_o && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      rd_q       <= 1'b0;
      evt_o      <= 1'b0;
      evt_addr_o <= '0;
      evt_data_o <= '0;
    end else begin
      act_q <= act;
      rd_q  <= rd_act_o;
      // Strobe finished by an enable rising, with oe_n still high.
      evt_o <= act_q && !act && oe_n;
      if (act && !act_q) evt_addr_o <= addr;
      if (act) evt_data_o <= din;
    end
  end

  assert_evt_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(act_q));
endmodule

// File: rtl/pgeep_page_buf.sv
// Page buffer: one data byte and one loaded flag per position.
module pgeep_page_buf #(
  parameter int PAGE_IDX_W = 7,
  parameter int DATA_W     = 8,
  localparam int PAGE_BYTES = 1 << PAGE_IDX_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [PAGE_IDX_W-1:0]               idx,
  input  logic [DATA_W-1:0]                   data,
  input  logic                                clear,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   bytes_o,
  output logic [PAGE_BYTES-1:0]               mask_o
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes_o[i] <= '0;
        mask_o[i]  <= 1'b0;
      end else if (clear) begin
        mask_o[i] <= 1'b0;
      end else if (wr_en && idx == PAGE_IDX_W'(i)) begin
        bytes_o[i] <= data;   // later strobe to the same slot wins (R6)
        mask_o[i]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgeep_seq.sv
// Load / program sequencer with the byte-load window and programming timers.
module pgeep_seq
  import pgeep_pkg::*;
#(
  parameter int PAGE_W           = 10,
  parameter int ARRAY_PAGES_LOG2 = 2,
  parameter int BLC_CYCLES       = 7500,
  parameter int PROG_CYCLES      = 500000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_i,
  input  logic [PAGE_W-1:0]           evt_page_i,
  input  logic                        unlock_i,
  output logic                        accept_o,
  output logic                        commit_o,
  output logic                        busy_o,
  output logic [ARRAY_PAGES_LOG2-1:0] page_lo_o
);
  localparam int MAX_CNT = (BLC_CYCLES > PROG_CYCLES) ? BLC_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  eng_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;

  always_comb begin
    accept_o = 1'b0;
    if (evt_i) begin
      if (state_q == ST_IDLE)      accept_o = unlock_i;
      else if (state_q == ST_LOAD) accept_o = (evt_page_i == page_q);
    end
  end

  assign commit_o  = (state_q == ST_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign busy_o    = (state_q == ST_PROG);
  assign page_lo_o = page_q[ARRAY_PAGES_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      page_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_LOAD;
          page_q  <= evt_page_i;
          cnt_q   <= '0;
        end
        ST_LOAD: begin
          if (accept_o) cnt_q <= '0;
          else if (cnt_q == CNT_W'(BLC_CYCLES - 1)) begin
            state_q <= ST_PROG;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PROG: begin
          if (commit_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_unlock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && evt_i && !unlock_i) |=> (state_q == ST_IDLE));

  assert_page_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && $past(state_q) == ST_LOAD) |-> $stable(page_q));
endmodule

// File: rtl/pgeep_write_engine.sv
module pgeep_write_engine #(
  parameter int ADDR_W           = 17,
  parameter int DATA_W           = 8,
  parameter int PAGE_IDX_W       = 7,
  parameter int ARRAY_PAGES_LOG2 = 2,
  parameter int BLC_CYCLES       = 7500,
  parameter int PROG_CYCLES      = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              unlock,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_IDX_W;
  localparam int PAGE_W     = ADDR_W - PAGE_IDX_W;
  localparam int ARR_W      = PAGE_IDX_W + ARRAY_PAGES_LOG2;
  localparam int ARR_DEPTH  = 1 << ARR_W;

  logic                              evt, rd_start, accept, commit;
  logic [ADDR_W-1:0]                 evt_addr;
  logic [DATA_W-1:0]                 evt_data, last_q, arr_byte;
  logic [ARRAY_PAGES_LOG2-1:0]       page_lo;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
  logic [PAGE_BYTES-1:0]             mask;
  logic                              tog_q;
  logic [DATA_W-1:0]                 mem [ARR_DEPTH];

  pgeep_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .evt_o(evt), .evt_addr_o(evt_addr),
    .evt_data_o(evt_data), .rd_act_o(dout_en), .rd_start_o(rd_start)
  );

  pgeep_seq #(
    .PAGE_W(PAGE_W), .ARRAY_PAGES_LOG2(ARRAY_PAGES_LOG2),
    .BLC_CYCLES(BLC_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .evt_page_i(evt_addr[ADDR_W-1:PAGE_IDX_W]), .unlock_i(unlock),
    .accept_o(accept), .commit_o(commit), .busy_o(busy), .page_lo_o(page_lo)
  );

  pgeep_page_buf #(.PAGE_IDX_W(PAGE_IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(accept),
    .idx(evt_addr[PAGE_IDX_W-1:0]), .data(evt_data), .clear(commit),
    .bytes_o(buf_bytes), .mask_o(mask)
  );

  // Storage array: erased to all ones, masked page copy at the end of programming.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ARR_DEPTH; k++) mem[k] <= '1;
    end else if (commit) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (mask[j]) mem[{page_lo, PAGE_IDX_W'(j)}] <= buf_bytes[j];
    end
  end

  // Status state: last accepted byte and the per-read toggle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (accept) last_q <= evt_data;
      if (!busy) tog_q <= 1'b0;
      else if (rd_start) tog_q <= ~tog_q;
    end
  end

  assign arr_byte = mem[addr[ARR_W-1:0]];

  always_comb begin
    dout = '0;
    if (dout_en) begin
      dout = arr_byte;
      if (busy) begin
        dout[DATA_W-1] = ~last_q[DATA_W-1];
        dout[DATA_W-2] = tog_q;
      end
    end
  end

  assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask));

  assert_mask_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));

  assert_tog_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(rd_start)) |-> $stable(tog_q));
endmodule

// File: tb/tb_pgeep_write_engine.sv
module tb_pgeep_write_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BLC  = 20;
  localparam int PROG = 60;
  localparam int NV   = 5;
  // {address, data written, expected read after programming}
  localparam logic [32:0] VEC [NV] = '{
    {17'h00085, 8'h3C, 8'hA7},
    {17'h00080, 8'h11, 8'h11},
    {17'h000FF, 8'h5A, 8'h5A},
    {17'h00100, 8'h77, 8'hFF},   // other page: dropped (R5)
    {17'h00085, 8'hA7, 8'hA7}    // overwrite (R6)
  };

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, unlock;
  logic [16:0] addr;
  logic [7:0]  din, dout;
  logic dout_en, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgeep_write_engine #(.BLC_CYCLES(BLC), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .unlock(unlock),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  int total = 0, bad = 0, cyc = 0, rise_cyc = -1, fall_cyc = -1;
  bit finished = 1'b0;
  logic busy_prev = 1'b0;

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (busy && !busy_prev) rise_cyc = cyc;
    if (!busy && busy_prev) fall_cyc = cyc;
    busy_prev = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; din = d; ce_n = 1'b0;
    @(posedge clk); #1 we_n = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 we_n = 1'b1;
    @(posedge clk); #1 ce_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic en);
    @(posedge clk); #1 addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #2 d = dout; en = dout_en;
    #1 oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, last;
    logic en;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    unlock = 1'b0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(dout_en == 1'b0, "R1 dout_en after reset", dout_en, 0);

    // R2: output enable needs both ce_n and oe_n low
    #1 ce_n = 1'b0; oe_n = 1'b1;
    #1 chk(dout_en == 1'b0 && dout == 8'h00, "R2 oe_n high", dout_en, 0);
    ce_n = 1'b1; oe_n = 1'b0;
    #1 chk(dout_en == 1'b0, "R2 ce_n high", dout_en, 0);
    oe_n = 1'b1;
    rd(17'h00005, d, en);
    chk(en == 1'b1, "R2 dout_en on read", en, 1);
    chk(d == 8'hFF, "R1 erased byte", d, 8'hFF);

    // R4: locked write is dropped
    wr(17'h00005, 8'h00);
    repeat (BLC + 10) @(posedge clk);
    #2 chk(busy == 1'b0, "R4 locked no program", busy, 0);
    rd(17'h00005, d, en);
    chk(d == 8'hFF, "R4 locked data unchanged", d, 8'hFF);

    // R3: strobe with oe_n low is inhibited
    unlock = 1'b1;
    @(posedge clk); #1 addr = 17'h00005; din = 8'h00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (BLC + 10) @(posedge clk);
    #2 chk(busy == 1'b0, "R3 oe_n low inhibit", busy, 0);

    // Vector table: one page load
    for (int i = 0; i < NV; i++) wr(VEC[i][32:16], VEC[i][15:8]);
    last = VEC[NV-1][15:8];
    repeat (BLC - 3) @(posedge clk);
    #2 chk(busy == 1'b0, "R7 window not yet elapsed", busy, 0);
    repeat (6) @(posedge clk);
    #2 chk(busy == 1'b1, "R7 programming started", busy, 1);

    // R9 / R10: status reads while programming
    for (int k = 0; k < 3; k++) begin
      rd(17'h00080, d, en);
      chk(d[7] == ~last[7], "R9 bit7 complement", d[7], ~last[7]);
      chk(d[6] == ((k % 2) == 0), "R10 bit6 alternation", d[6], (k % 2) == 0);
    end
    // R8: write during programming is dropped
    wr(17'h00180, 8'h42);
    wait_idle();
    chk(fall_cyc - rise_cyc == PROG, "R8 programming length", fall_cyc - rise_cyc, PROG);
    repeat (BLC + 10) @(posedge clk);
    #2 chk(busy == 1'b0, "R8 no load after busy write", busy, 0);
    rd(17'h00180, d, en);
    chk(d == 8'hFF, "R8 busy write not stored", d, 8'hFF);

    // R5 / R6 / R11: readback of the table
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][32:16], d, en);
      chk(d == VEC[i][7:0], "R6 R5 readback", d, VEC[i][7:0]);
    end
    rd(17'h00081, d, en);
    chk(d == 8'hFF, "R6 unloaded byte kept", d, 8'hFF);
    rd(17'h00080, d, en);
    chk(d == 8'h11, "R11 true data after done", d, 8'h11);
    rd(17'h00080, d, en);
    chk(d == 8'h11, "R11 bit6 stable after done", d, 8'h11);

    // R6: second load of one byte leaves others intact
    wr(17'h000C0, 8'h09);
    for (int i = 0; i < 200 && !busy; i++) @(posedge clk);
    wait_idle();
    rd(17'h000C0, d, en);
    chk(d == 8'h09, "R6 single byte programmed", d, 8'h09);
    rd(17'h00080, d, en);
    chk(d == 8'h11, "R6 other byte untouched", d, 8'h11);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule